// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

This block is a bank of general-purpose I/O lines behind a small register interface. The interface is word-addressed and takes an address, a write strobe and write data, and it returns read data without delay. Each line can be a static output, a blinking output or an input. Inputs pass through a two-stage synchronizer. A per-line polarity bit is then applied, and the result is what software reads as the line's input value.

The polarity-adjusted input feeds two interrupt sources. The level source is the input value gated by a level-enable bit, and it is not latched. The edge source is a sticky event bit, set when the adjusted input goes from 0 to 1 and cleared by software. With polarity 0 this catches rising pad edges and with polarity 1 it catches falling ones. Software can catch both edges by flipping the polarity after each event. The two sources are combined per line and then OR-reduced in groups of eight lines, one interrupt output per group.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, padOut is all 0 and padOe is all 0, because every line is an input. The event, edge-enable and level-enable registers read 0 and irqOut is 0.
- R2: The register map uses these word addresses: 0x00 output value, 0x04 direction, 0x08 blink enable, 0x0C polarity, 0x10 input value (read-only), 0x14 event, 0x18 edge enable, 0x1C level enable. A direction bit of 1 makes the line an input, and padOe is the inverse of the direction register. A non-blinking line drives its output-value bit on padOut in the cycle after the write.
- R3: A read of 0x10 returns the synchronized pad level XOR the polarity register. Writes to 0x10 change no register.
- R4: With polarity 0, a rising pad edge sets the line's event bit. A falling pad edge does not. With polarity 1, a falling pad edge sets the bit.
- R5: Event bits are sticky. A write to 0x14 clears each bit written 0 and keeps each bit written 1.
- R6: If an edge is detected in the same cycle as a write that clears its event bit, the bit stays set.
- R7: The level source is input value AND level enable. It follows the pad (after synchronization) with no latching.
- R8: An event bit raises an interrupt only while its edge-enable bit is 1. The event bit stays readable while it is disabled.
- R9: irqOut[g] is the OR of the pending bits of lines 8g to 8g+7, where pending = (input value AND level enable) OR (event AND edge enable).
- R10: A line whose blink bit is 1 toggles on padOut every BLINK_HALF cycles. All blinking lines toggle in phase, and clearing the blink bit restores the static value.
- R11: A pad change appears in the input value after the second rising clock edge, not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Byte address. Must be word aligned with upper bits 0, otherwise the write is ignored |
| regWrite | input | 1 | Write strobe, one cycle per write |
| regWdata | input | NLINES | Write data |
| regRdata | output | NLINES | Read data for regAddr, same cycle |
| padIn | input | NLINES | Asynchronous pad levels |
| padOut | output | NLINES | Pad output values |
| padOe | output | NLINES | Pad output enables, 1 = drive |
| irqOut | output | NLINES/GROUP_SIZE | Grouped interrupt requests |

## Verification
Suppose an event bit is lost or set wrongly. That shows on irqOut in the same cycle once its edge enable is set, and on the next read of 0x14. A synchronizer with the wrong depth moves the first visible change of the input value by one cycle, so the bench samples it after exactly one and after exactly two edges. A blink prescaler with the wrong period, or blinking lines out of phase, shows on padOut within one half-period. The bench counts the cycles between toggles and compares the two lines at every sample.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word index of each register (address bits [4:2])
  typedef enum logic [2:0] {
    SEL_OUT   = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_BLINK = 3'd2,
    SEL_POL   = 3'd3,
    SEL_DIN   = 3'd4,
    SEL_CAUSE = 3'd5,
    SEL_EMASK = 3'd6,
    SEL_LMASK = 3'd7
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrOut;
    logic    wrDir;
    logic    wrBlink;
    logic    wrPol;
    logic    wrCause;
    logic    wrEdgeMask;
    logic    wrLevelMask;
    logic    blinkPhase;
    regSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int BLINK_HALF = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  output ctlStrobes_t       ctl
);

  localparam int CNT_W = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_HALF - 1);

  logic [CNT_W-1:0] preCnt;
  logic             phase;
  logic             addrOk;
  regSel_e          sel;

  // Only aligned addresses inside the 32-byte window decode
  assign addrOk = ((regAddr >> 5) == '0) && (regAddr[1:0] == 2'b00);
  assign sel    = regSel_e'(regAddr[4:2]);

  always_comb begin
    ctl            = '0;
    ctl.rdSel      = sel;
    ctl.blinkPhase = phase;
    if (regWrite && addrOk) begin
      unique case (sel)
        SEL_OUT:   ctl.wrOut       = 1'b1;
        SEL_DIR:   ctl.wrDir       = 1'b1;
        SEL_BLINK: ctl.wrBlink     = 1'b1;
        SEL_POL:   ctl.wrPol       = 1'b1;
        SEL_DIN:   ;
        SEL_CAUSE: ctl.wrCause     = 1'b1;
        SEL_EMASK: ctl.wrEdgeMask  = 1'b1;
        SEL_LMASK: ctl.wrLevelMask = 1'b1;
        default:   ;
      endcase
    end
  end

  // Shared blink prescaler: phase flips every BLINK_HALF cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      phase  <= 1'b0;
    end else if (preCnt == CNT_LAST) begin
      preCnt <= '0;
      phase  <= ~phase;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NLINES     = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NGROUPS   = NLINES / GROUP_SIZE
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [NLINES-1:0] wdata,
  input  logic [NLINES-1:0] padIn,
  output logic [NLINES-1:0] padOut,
  output logic [NLINES-1:0] padOe,
  output logic [NGROUPS-1:0] irqOut,
  output logic [NLINES-1:0] rdata,
  output logic [NLINES-1:0] causeQ,
  output logic [NLINES-1:0] edgeMaskQ,
  output logic [NLINES-1:0] levelMaskQ,
  output logic [NLINES-1:0] dataInQ,
  output logic [NLINES-1:0] blinkQ
);

  logic [NLINES-1:0] outQ, dirQ, polQ;
  logic [NLINES-1:0] syncA, syncB, prevIn;
  logic [NLINES-1:0] edgeEvt, causeKeep, pending;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ       <= '0;
      dirQ       <= '1;
      blinkQ     <= '0;
      polQ       <= '0;
      edgeMaskQ  <= '0;
      levelMaskQ <= '0;
    end else begin
      if (ctl.wrOut)       outQ       <= wdata;
      if (ctl.wrDir)       dirQ       <= wdata;
      if (ctl.wrBlink)     blinkQ     <= wdata;
      if (ctl.wrPol)       polQ       <= wdata;
      if (ctl.wrEdgeMask)  edgeMaskQ  <= wdata;
      if (ctl.wrLevelMask) levelMaskQ <= wdata;
    end
  end

  // Two-flop synchronizer and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      prevIn <= '0;
    end else begin
      syncA  <= padIn;
      syncB  <= syncA;
      prevIn <= dataInQ;
    end
  end

  assign dataInQ = syncB ^ polQ;
  assign edgeEvt = dataInQ & ~prevIn;

  // Write-0-to-clear; a new event overrides a clear in the same cycle
  assign causeKeep = ctl.wrCause ? wdata : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) causeQ <= '0;
    else       causeQ <= (causeQ & causeKeep) | edgeEvt;
  end

  assign pending = (dataInQ & levelMaskQ) | (causeQ & edgeMaskQ);

  for (genvar g = 0; g < NGROUPS; g++) begin : gGroup
    assign irqOut[g] = |pending[g*GROUP_SIZE +: GROUP_SIZE];
  end

  assign padOut = (outQ & ~blinkQ) | (blinkQ & {NLINES{ctl.blinkPhase}});
  assign padOe  = ~dirQ;

  always_comb begin
    unique case (ctl.rdSel)
      SEL_OUT:   rdata = outQ;
      SEL_DIR:   rdata = dirQ;
      SEL_BLINK: rdata = blinkQ;
      SEL_POL:   rdata = polQ;
      SEL_DIN:   rdata = dataInQ;
      SEL_CAUSE: rdata = causeQ;
      SEL_EMASK: rdata = edgeMaskQ;
      SEL_LMASK: rdata = levelMaskQ;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NLINES     = 32,
  parameter int GROUP_SIZE = 8,
  parameter int ADDR_W     = 5,
  parameter int BLINK_HALF = 16,
  localparam int NGROUPS   = NLINES / GROUP_SIZE
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrite,
  input  logic [NLINES-1:0]  regWdata,
  output logic [NLINES-1:0]  regRdata,
  input  logic [NLINES-1:0]  padIn,
  output logic [NLINES-1:0]  padOut,
  output logic [NLINES-1:0]  padOe,
  output logic [NGROUPS-1:0] irqOut
);

  ctlStrobes_t       ctl;
  logic [NLINES-1:0] causeQ, edgeMaskQ, levelMaskQ, dataInQ, blinkQ;

  gpio_irq_ctrl #(
    .ADDR_W     (ADDR_W),
    .BLINK_HALF (BLINK_HALF)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrite (regWrite),
    .ctl      (ctl)
  );

  gpio_irq_dp #(
    .NLINES     (NLINES),
    .GROUP_SIZE (GROUP_SIZE)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .wdata      (regWdata),
    .padIn      (padIn),
    .padOut     (padOut),
    .padOe      (padOe),
    .irqOut     (irqOut),
    .rdata      (regRdata),
    .causeQ     (causeQ),
    .edgeMaskQ  (edgeMaskQ),
    .levelMaskQ (levelMaskQ),
    .dataInQ    (dataInQ),
    .blinkQ     (blinkQ)
  );

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NLINES     = 32,
  parameter int GROUP_SIZE = 8,
  parameter int ADDR_W     = 5,
  localparam int NGROUPS   = NLINES / GROUP_SIZE
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrite,
  input logic [NLINES-1:0]  regWdata,
  input logic [NLINES-1:0]  padOut,
  input logic [NLINES-1:0]  padOe,
  input logic [NGROUPS-1:0] irqOut,
  input logic               causeWr,
  input logic [NLINES-1:0]  causeQ,
  input logic [NLINES-1:0]  edgeMaskQ,
  input logic [NLINES-1:0]  levelMaskQ,
  input logic [NLINES-1:0]  dataInQ,
  input logic [NLINES-1:0]  blinkQ
);

  logic [NLINES-1:0] srcSeen;
  assign srcSeen = (dataInQ & levelMaskQ) | (causeQ & edgeMaskQ);

  // R1
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgeMaskQ == '0 && levelMaskQ == '0) |-> (irqOut == '0));

  // R2
  dir_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_W'(4)) |=> (padOe == ~$past(regWdata)));

  // R2
  static_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_W'(0) && blinkQ == '0) |=> (padOut == $past(regWdata)));

  // R5
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !causeWr |=> (($past(causeQ) & ~causeQ) == '0));

  for (genvar g = 0; g < NGROUPS; g++) begin : gGrp
    // R9
    group_or_chk: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[g] == (|srcSeen[g*GROUP_SIZE +: GROUP_SIZE]));
  end

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NLINES     (NLINES),
  .GROUP_SIZE (GROUP_SIZE),
  .ADDR_W     (ADDR_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regWrite   (regWrite),
  .regWdata   (regWdata),
  .padOut     (padOut),
  .padOe      (padOe),
  .irqOut     (irqOut),
  .causeWr    (ctl.wrCause),
  .causeQ     (causeQ),
  .edgeMaskQ  (edgeMaskQ),
  .levelMaskQ (levelMaskQ),
  .dataInQ    (dataInQ),
  .blinkQ     (blinkQ)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;

  localparam int HALF = 16;
  localparam logic [4:0] A_OUT = 5'h00, A_DIR = 5'h04, A_BLINK = 5'h08, A_POL = 5'h0C,
                         A_DIN = 5'h10, A_CAUSE = 5'h14, A_EMASK = 5'h18, A_LMASK = 5'h1C;

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  regAddr;
  logic        regWrite;
  logic [31:0] regWdata, regRdata, padIn, padOut, padOe;
  logic [3:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NLINES(32), .GROUP_SIZE(8), .ADDR_W(5), .BLINK_HALF(HALF)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite), .regWdata(regWdata),
    .regRdata(regRdata), .padIn(padIn), .padOut(padOut), .padOe(padOe), .irqOut(irqOut)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic testReset;
    logic [31:0] v;
    chk("R1", "padOut", padOut, 32'h0);
    chk("R1", "padOe", padOe, 32'h0);
    chk("R1", "irqOut", {28'h0, irqOut}, 32'h0);
    rd(A_CAUSE, v); chk("R1", "event reg", v, 32'h0);
    rd(A_EMASK, v); chk("R1", "edge enable", v, 32'h0);
    rd(A_LMASK, v); chk("R1", "level enable", v, 32'h0);
  endtask

  task automatic testOutputs;
    logic [31:0] v;
    wr(A_DIR, 32'hFFFF_0000);
    chk("R2", "padOe inverse of direction", padOe, 32'h0000_FFFF);
    wr(A_OUT, 32'hA5A5_1234);
    chk("R2", "padOut static", padOut, 32'hA5A5_1234);
    rd(A_OUT, v); chk("R2", "output readback", v, 32'hA5A5_1234);
  endtask

  task automatic testSync;
    logic [31:0] v;
    padIn[5] = 1'b1;
    tick(1); rd(A_DIN, v); chk("R11", "input after one edge", v, 32'h0);
    tick(1); rd(A_DIN, v); chk("R11", "input after two edges", v, 32'h20);
    wr(A_POL, 32'h20);
    rd(A_DIN, v); chk("R3", "polarity inverts input", v, 32'h0);
    wr(A_DIN, 32'hFFFF_FFFF);
    rd(A_DIN, v); chk("R3", "input value after write to 0x10", v, 32'h0);
    rd(A_POL, v); chk("R3", "polarity untouched by write to 0x10", v, 32'h20);
    wr(A_POL, 32'h0);
    padIn[5] = 1'b0;
    tick(3);
    wr(A_CAUSE, 32'h0);
  endtask

  task automatic testEdges;
    logic [31:0] v;
    padIn[3] = 1'b1; tick(3);
    rd(A_CAUSE, v); chk("R4", "rising edge polarity 0", v, 32'h8);
    wr(A_CAUSE, 32'h0);
    padIn[3] = 1'b0; tick(4);
    rd(A_CAUSE, v); chk("R4", "falling edge ignored with polarity 0", v, 32'h0);
    padIn[9] = 1'b1; tick(3);
    wr(A_POL, 32'h200); tick(1);
    wr(A_CAUSE, 32'h0);
    padIn[9] = 1'b0; tick(3);
    rd(A_CAUSE, v); chk("R4", "falling edge polarity 1", v, 32'h200);
    padIn[3] = 1'b1; tick(3);
    rd(A_CAUSE, v); chk("R4", "two events held", v, 32'h208);
  endtask

  task automatic testClear;
    logic [31:0] v;
    wr(A_CAUSE, ~32'h8);
    rd(A_CAUSE, v); chk("R5", "clear single bit", v, 32'h200);
    wr(A_CAUSE, 32'hFFFF_FFFF);
    rd(A_CAUSE, v); chk("R5", "ones keep bits", v, 32'h200);
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, v); chk("R5", "zeros clear bits", v, 32'h0);
    wr(A_POL, 32'h0);
    padIn[3] = 1'b0; tick(3);
  endtask

  task automatic testEventWins;
    logic [31:0] v;
    padIn[14] = 1'b1; tick(3);
    rd(A_CAUSE, v); chk("R6", "first event", v, 32'h4000);
    padIn[14] = 1'b0; tick(3);
    padIn[14] = 1'b1;
    tick(2);
    regAddr = A_CAUSE; regWdata = 32'h0; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
    rd(A_CAUSE, v); chk("R6", "event wins over clear", v, 32'h4000);
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, v); chk("R5", "later clear", v, 32'h0);
    padIn[14] = 1'b0; tick(3);
  endtask

  task automatic testLevel;
    wr(A_LMASK, 32'h1000);
    padIn[12] = 1'b1;
    tick(1); chk("R7", "level before sync", {28'h0, irqOut}, 32'h0);
    tick(1); chk("R7", "level asserted", {28'h0, irqOut}, 32'h2);
    padIn[12] = 1'b0;
    tick(2); chk("R7", "level not latched", {28'h0, irqOut}, 32'h0);
    wr(A_LMASK, 32'h0);
    wr(A_CAUSE, 32'h0);
  endtask

  task automatic testEdgeMask;
    logic [31:0] v;
    padIn[20] = 1'b1; tick(3);
    chk("R8", "disabled event no irq", {28'h0, irqOut}, 32'h0);
    rd(A_CAUSE, v); chk("R8", "disabled event readable", v, 32'h0010_0000);
    wr(A_EMASK, 32'h0010_0000);
    chk("R8", "enabled event irq", {28'h0, irqOut}, 32'h4);
    padIn[20] = 1'b0; tick(3);
    chk("R8", "event irq after pad returns", {28'h0, irqOut}, 32'h4);
    wr(A_CAUSE, ~32'h0010_0000);
    chk("R8", "cleared event drops irq", {28'h0, irqOut}, 32'h0);
    wr(A_EMASK, 32'h0);
  endtask

  task automatic testGroups;
    for (int g = 0; g < 4; g++) begin
      int line;
      line = g * 8 + g * 2;
      wr(A_POL, 32'h1 << line);
      wr(A_LMASK, 32'h1 << line);
      chk("R9", $sformatf("group of line %0d", line), {28'h0, irqOut}, 32'h1 << g);
      wr(A_LMASK, 32'h0);
      wr(A_POL, 32'h0);
    end
    wr(A_CAUSE, 32'h0);
  endtask

  task automatic testBlink;
    logic prev;
    int n;
    int mism;
    bit seen;
    wr(A_DIR, 32'h0);
    wr(A_OUT, 32'h2);
    wr(A_BLINK, 32'h8000_0001);
    prev = padOut[0];
    seen = 1'b0;
    for (int k = 0; k < 3 * HALF && !seen; k++) begin
      tick(1);
      if (padOut[0] != prev) seen = 1'b1;
    end
    chk("R10", "blink toggles", {31'h0, seen}, 32'h1);
    prev = padOut[0];
    n = 0; mism = 0; seen = 1'b0;
    for (int k = 0; k < 3 * HALF && !seen; k++) begin
      tick(1); n++;
      if (padOut[31] != padOut[0]) mism++;
      if (padOut[1] != 1'b1) mism++;
      if (padOut[0] != prev) seen = 1'b1;
    end
    chk("R10", "half period cycles", n, HALF);
    chk("R10", "in phase, static line held", mism, 0);
    wr(A_BLINK, 32'h0);
    chk("R10", "static value restored", padOut, 32'h2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      report;
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regAddr = '0; regWrite = 1'b0; regWdata = '0; padIn = '0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset;
    testOutputs;
    testSync;
    testEdges;
    testClear;
    testEventWins;
    testLevel;
    testEdgeMask;
    testGroups;
    testBlink;
    done = 1'b1;
    report;
    $finish;
  end

endmodule